// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of a parallel NOR-style flash device. It watches every bus write (address plus data). It recognises the multi-cycle command sequences that start with the two-write unlock handshake: data AA at offset 555, then data 55 at offset 2AA. It tracks the interpretation mode of the bank: array reading, identifier reading, query reading or the unlock-bypass shortcut mode. It also tracks whether a sector erase is running or suspended.

The block does not touch the memory array or the embedded algorithms. It issues one-cycle strobes for program start, chip erase, sector erase, suspend, resume and configuration-register write. Each strobe comes with the captured operation address and data. The block also drives a read-path select and the identifier byte. The embedded-operation busy state and the high-voltage accelerate flag arrive as inputs.

Every strobe is registered. It is high for exactly one clock, in the cycle after the clock edge that samples the completing write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read select is 0 (array), no strobe is high, bypass mode and erase-suspended are both 0.
- R2: The write sequence AA@555, 55@2AA, A0@555, then (PA, PD) raises prog_stb for one cycle. op_addr equals PA and op_data equals PD at full width. Any PD value is accepted, F0 included.
- R3: After AA@555, 55@2AA, 80@555, AA@555, 55@2AA, a sixth write decides the erase. 10@555 raises chip_erase_stb. 30 at any address raises sect_erase_stb, with op_addr equal to that address.
- R4: A write that does not match the expected next step of a sequence returns the decoder to idle without any strobe. A following complete sequence is then decoded normally.
- R5: Unlock, command-offset and command-code matching use only address bits 11..0 and data bits 7..0. Higher bits do not matter.
- R6: AA@555, 55@2AA, 90@555 sets the read select to 1 (identifier). The identifier byte for read offsets 00, 01, 0E and 0F is 01, 7E, 09 and the ORDER_OPT parameter; every other offset gives 00. In this mode every write except data F0 is ignored. F0 returns the read select to 0.
- R7: Data 98 at offset 055 sets the read select to 2 (query), but only in array mode with no suspended erase. 98 at any other offset has no effect. F0 leaves query mode.
- R8: B0 raises suspend_stb and sets erase_suspended, but only while a sector erase is running. A running sector erase starts with sect_erase_stb or resume_stb and ends on a falling edge of op_busy. At any other time B0 has no effect.
- R9: 30 written in array mode raises resume_stb and clears erase_suspended, but only while suspended. F0 written while suspended keeps the suspension.
- R10: AA@555, 55@2AA, D0@555, then WD raises cfg_wr_stb with op_data equal to WD. No strobe is issued if op_busy is high or an erase is suspended at the WD write.
- R11: With acc_hv high, A0 at any address followed by (PA, PD) raises prog_stb. With acc_hv low, the same two writes give no strobe.
- R12: AA@555, 55@2AA, 20@555 sets bypass_on. In bypass mode: A0 then (PA, PD) programs; 80 then 10 raises chip_erase_stb; F0 is ignored; 90 then 00 clears bypass_on.
- R13: While an erase is suspended, the erase and bypass-entry sequences give no strobe and no mode change. The program sequence still raises prog_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| acc_hv | input | 1 | High-voltage accelerate flag |
| op_busy | input | 1 | Embedded program/erase in progress |
| rd_ofs | input | ID_OFS_W | Read offset inside the bank for identifier reads |
| prog_stb | output | 1 | Start program at op_addr with op_data |
| chip_erase_stb | output | 1 | Start chip erase |
| sect_erase_stb | output | 1 | Start sector erase of the sector at op_addr |
| suspend_stb | output | 1 | Suspend the running sector erase |
| resume_stb | output | 1 | Resume the suspended erase |
| cfg_wr_stb | output | 1 | Write op_data to the configuration register |
| op_addr | output | ADDR_W | Captured operation address |
| op_data | output | DATA_W | Captured operation data |
| rd_sel | output | 2 | Read path: 0 array, 1 identifier, 2 query |
| id_byte | output | 8 | Identifier byte for rd_ofs |
| bypass_on | output | 1 | Unlock-bypass mode active |
| erase_suspended | output | 1 | A sector erase is suspended |

## Verification
The hardest state to reach from the ports is the suspended sector erase. The bench first issues a full six-write sector erase. It then raises op_busy as the embedded algorithm would and suspends with B0. It lowers op_busy while suspended. From inside that state it runs the refused erase, the refused configuration write and the still-allowed program. It then resumes, and a busy pulse ends the erase. This shows that a later B0 or 30 is refused.

// File: rtl/fcd_pkg.sv
// Package: shared types and command constants of the flash command decoder.
// Assumes command codes sit in data bits 7..0 and command offsets in address bits 11..0.
package fcd_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,      // waiting for the first write of a sequence
        SQ_U1,        // first unlock write seen
        SQ_U2,        // unlock pair complete
        SQ_PROG,      // waiting for program address/data
        SQ_E1,        // erase setup seen
        SQ_E2,        // erase setup + first unlock
        SQ_E3,        // erase setup + unlock pair
        SQ_CFG,       // waiting for configuration data
        SQ_BP_PROG,   // bypass program armed
        SQ_BP_ERASE,  // bypass erase armed
        SQ_BP_EXIT,   // bypass exit armed
        SQ_ACC        // accelerated program armed
    } seq_t;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_IDREAD = 2'd1,
        MD_QUERY  = 2'd2,
        MD_BYPASS = 2'd3
    } mode_t;

    localparam logic [1:0] RSEL_ARRAY = 2'd0;
    localparam logic [1:0] RSEL_ID    = 2'd1;
    localparam logic [1:0] RSEL_QUERY = 2'd2;

    localparam logic [11:0] OFS_KEY_A = 12'h555;
    localparam logic [11:0] OFS_KEY_B = 12'h2AA;
    localparam logic [11:0] OFS_QUERY = 12'h055;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_ERSETUP  = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECT_RES = 8'h30;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_CFG      = 8'hD0;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_BPEXIT   = 8'h00;

endpackage

// File: rtl/fcd_cmd_classify.sv
// Module: classifies one bus write into offset and code matches.
// Assumes the caller passes only address bits 11..0 and data bits 7..0,
// so higher bits cannot influence decoding.
module fcd_cmd_classify
    import fcd_pkg::*;
(
    input  logic [11:0] ofs,
    input  logic [7:0]  code,
    output logic        at_key_a,
    output logic        at_query,
    output logic        is_key_a,
    output logic        is_key_b
);

    // Offset and unlock-pattern comparison.
    always_comb begin
        at_key_a = (ofs == OFS_KEY_A);
        at_query = (ofs == OFS_QUERY);
        is_key_a = at_key_a && (code == CMD_KEY_A);
        is_key_b = (ofs == OFS_KEY_B) && (code == CMD_KEY_B);
    end

endmodule

// File: rtl/fcd_id_table.sv
// Module: identifier byte lookup by read offset.
// Assumes the read path selects this byte only while in identifier mode.
module fcd_id_table #(
    parameter int          ID_OFS_W  = 8,
    parameter logic [7:0]  ORDER_OPT = 8'h00
) (
    input  logic [ID_OFS_W-1:0] ofs,
    output logic [7:0]          id_byte
);

    localparam logic [ID_OFS_W-1:0] OFS_MFR  = ID_OFS_W'(0);
    localparam logic [ID_OFS_W-1:0] OFS_DEV0 = ID_OFS_W'(1);
    localparam logic [ID_OFS_W-1:0] OFS_DEV1 = ID_OFS_W'(14);
    localparam logic [ID_OFS_W-1:0] OFS_DEV2 = ID_OFS_W'(15);

    // Map offset to identifier byte; unknown offsets read zero.
    always_comb begin
        if (ofs == OFS_MFR)       id_byte = 8'h01;
        else if (ofs == OFS_DEV0) id_byte = 8'h7E;
        else if (ofs == OFS_DEV1) id_byte = 8'h09;
        else if (ofs == OFS_DEV2) id_byte = ORDER_OPT;
        else                      id_byte = 8'h00;
    end

endmodule

// File: rtl/fcd_seq_ctrl.sv
// Module: command sequence state machine and bank mode tracker.
// Assumes writes last one cycle each and that op_busy falls when an embedded
// erase ends. All strobes are registered and last exactly one cycle.
module fcd_seq_ctrl
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              at_key_a,
    input  logic              at_query,
    input  logic              is_key_a,
    input  logic              is_key_b,
    input  logic              acc_hv,
    input  logic              op_busy,
    output logic              prog_stb,
    output logic              chip_erase_stb,
    output logic              sect_erase_stb,
    output logic              suspend_stb,
    output logic              resume_stb,
    output logic              cfg_wr_stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output mode_t             mode,
    output logic              suspended
);

    seq_t              seq, seq_n;
    mode_t             mode_n;
    logic              susp_n, erasing, ers_n, busy_q;
    logic              prog_n, ce_n, se_n, sus_n, res_n, cfg_n;
    logic [ADDR_W-1:0] addr_n;
    logic [DATA_W-1:0] data_n;
    logic [7:0]        code;

    assign code = wr_data[7:0];

    // Next-state decode of the current write against sequence and mode.
    always_comb begin
        seq_n  = seq;
        mode_n = mode;
        susp_n = suspended;
        ers_n  = erasing;
        addr_n = op_addr;
        data_n = op_data;
        prog_n = 1'b0;
        ce_n   = 1'b0;
        se_n   = 1'b0;
        sus_n  = 1'b0;
        res_n  = 1'b0;
        cfg_n  = 1'b0;
        if (busy_q && !op_busy) ers_n = 1'b0;
        if (wr_en) begin
            seq_n = SQ_IDLE;
            unique case (seq)
                SQ_IDLE: begin
                    unique case (mode)
                        MD_IDREAD, MD_QUERY: begin
                            if (code == CMD_RESET) mode_n = MD_ARRAY;
                        end
                        MD_BYPASS: begin
                            if (code == CMD_PROG)         seq_n = SQ_BP_PROG;
                            else if (code == CMD_ERSETUP) seq_n = SQ_BP_ERASE;
                            else if (code == CMD_IDENT)   seq_n = SQ_BP_EXIT;
                        end
                        default: begin
                            if (is_key_a) begin
                                seq_n = SQ_U1;
                            end else if (code == CMD_QUERY && at_query && !suspended) begin
                                mode_n = MD_QUERY;
                            end else if (code == CMD_SUSPEND && erasing) begin
                                sus_n  = 1'b1;
                                susp_n = 1'b1;
                                ers_n  = 1'b0;
                            end else if (code == CMD_SECT_RES && suspended) begin
                                res_n  = 1'b1;
                                susp_n = 1'b0;
                                ers_n  = 1'b1;
                            end else if (code == CMD_PROG && acc_hv) begin
                                seq_n = SQ_ACC;
                            end
                        end
                    endcase
                end
                SQ_U1: if (is_key_b) seq_n = SQ_U2;
                SQ_U2: begin
                    if (at_key_a) begin
                        if (code == CMD_PROG) seq_n = SQ_PROG;
                        else if (code == CMD_ERSETUP && !suspended) seq_n = SQ_E1;
                        else if (code == CMD_IDENT) mode_n = MD_IDREAD;
                        else if (code == CMD_BYPASS && !suspended) mode_n = MD_BYPASS;
                        else if (code == CMD_CFG) seq_n = SQ_CFG;
                    end
                end
                SQ_E1: if (is_key_a) seq_n = SQ_E2;
                SQ_E2: if (is_key_b) seq_n = SQ_E3;
                SQ_E3: begin
                    if (code == CMD_CHIP && at_key_a) begin
                        ce_n = 1'b1;
                    end else if (code == CMD_SECT_RES) begin
                        se_n   = 1'b1;
                        ers_n  = 1'b1;
                        addr_n = wr_addr;
                    end
                end
                SQ_PROG, SQ_ACC, SQ_BP_PROG: begin
                    prog_n = 1'b1;
                    addr_n = wr_addr;
                    data_n = wr_data;
                end
                SQ_CFG: begin
                    if (!op_busy && !suspended) begin
                        cfg_n  = 1'b1;
                        data_n = wr_data;
                    end
                end
                SQ_BP_ERASE: if (code == CMD_CHIP) ce_n = 1'b1;
                SQ_BP_EXIT:  if (code == CMD_BPEXIT) mode_n = MD_ARRAY;
                default: seq_n = SQ_IDLE;
            endcase
        end
    end

    // State, mode and strobe registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq            <= SQ_IDLE;
            mode           <= MD_ARRAY;
            suspended      <= 1'b0;
            erasing        <= 1'b0;
            busy_q         <= 1'b0;
            op_addr        <= '0;
            op_data        <= '0;
            prog_stb       <= 1'b0;
            chip_erase_stb <= 1'b0;
            sect_erase_stb <= 1'b0;
            suspend_stb    <= 1'b0;
            resume_stb     <= 1'b0;
            cfg_wr_stb     <= 1'b0;
        end else begin
            seq            <= seq_n;
            mode           <= mode_n;
            suspended      <= susp_n;
            erasing        <= ers_n;
            busy_q         <= op_busy;
            op_addr        <= addr_n;
            op_data        <= data_n;
            prog_stb       <= prog_n;
            chip_erase_stb <= ce_n;
            sect_erase_stb <= se_n;
            suspend_stb    <= sus_n;
            resume_stb     <= res_n;
            cfg_wr_stb     <= cfg_n;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the flash command decoder.
// Classifies writes, runs the sequence machine and drives the read-path
// select and identifier byte. Assumes ADDR_W >= 12 and DATA_W >= 8.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W    = 20,
    parameter int         DATA_W    = 32,
    parameter int         ID_OFS_W  = 8,
    parameter logic [7:0] ORDER_OPT = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                acc_hv,
    input  logic                op_busy,
    input  logic [ID_OFS_W-1:0] rd_ofs,
    output logic                prog_stb,
    output logic                chip_erase_stb,
    output logic                sect_erase_stb,
    output logic                suspend_stb,
    output logic                resume_stb,
    output logic                cfg_wr_stb,
    output logic [ADDR_W-1:0]   op_addr,
    output logic [DATA_W-1:0]   op_data,
    output logic [1:0]          rd_sel,
    output logic [7:0]          id_byte,
    output logic                bypass_on,
    output logic                erase_suspended
);

    logic  at_key_a, at_query, is_key_a, is_key_b;
    mode_t mode;

    fcd_cmd_classify u_classify (
        .ofs      (wr_addr[11:0]),
        .code     (wr_data[7:0]),
        .at_key_a (at_key_a),
        .at_query (at_query),
        .is_key_a (is_key_a),
        .is_key_b (is_key_b)
    );

    fcd_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .at_key_a       (at_key_a),
        .at_query       (at_query),
        .is_key_a       (is_key_a),
        .is_key_b       (is_key_b),
        .acc_hv         (acc_hv),
        .op_busy        (op_busy),
        .prog_stb       (prog_stb),
        .chip_erase_stb (chip_erase_stb),
        .sect_erase_stb (sect_erase_stb),
        .suspend_stb    (suspend_stb),
        .resume_stb     (resume_stb),
        .cfg_wr_stb     (cfg_wr_stb),
        .op_addr        (op_addr),
        .op_data        (op_data),
        .mode           (mode),
        .suspended      (erase_suspended)
    );

    fcd_id_table #(
        .ID_OFS_W  (ID_OFS_W),
        .ORDER_OPT (ORDER_OPT)
    ) u_id (
        .ofs     (rd_ofs),
        .id_byte (id_byte)
    );

    // Read-path select and bypass flag follow the bank mode.
    always_comb begin
        unique case (mode)
            MD_IDREAD: rd_sel = RSEL_ID;
            MD_QUERY:  rd_sel = RSEL_QUERY;
            default:   rd_sel = RSEL_ARRAY;
        endcase
        bypass_on = (mode == MD_BYPASS);
    end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Checker: temporal properties of the decoder's ports, bound to the top.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module flash_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] cmd_byte,
    input logic       op_busy,
    input logic       prog_stb,
    input logic       chip_erase_stb,
    input logic       sect_erase_stb,
    input logic       suspend_stb,
    input logic       resume_stb,
    input logic       cfg_wr_stb,
    input logic [1:0] rd_sel,
    input logic       bypass_on,
    input logic       erase_suspended
);

    // R4: a write completes at most one sequence, so at most one strobe.
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb, cfg_wr_stb}));

    // R2: a program strobe needs a fresh write, so it never lasts two cycles.
    assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> !prog_stb);

    // R8: a suspend strobe follows a B0 write.
    assert_suspend_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_stb |-> ($past(wr_en) && $past(cmd_byte) == 8'hB0));

    // R9: resume only from the suspended state.
    assert_resume_needs_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> $past(erase_suspended));

    // R10: no configuration write while busy or suspended.
    assert_cfg_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_stb |-> (!$past(op_busy) && !$past(erase_suspended)));

    // R6: leaving identifier mode needs an F0 write.
    assert_id_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_sel) == 2'd1 && rd_sel == 2'd0) |-> ($past(wr_en) && $past(cmd_byte) == 8'hF0));

    // R12: leaving bypass mode needs the 00 write.
    assert_bypass_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_on) |-> ($past(wr_en) && $past(cmd_byte) == 8'h00));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .cmd_byte        (wr_data[7:0]),
    .op_busy         (op_busy),
    .prog_stb        (prog_stb),
    .chip_erase_stb  (chip_erase_stb),
    .sect_erase_stb  (sect_erase_stb),
    .suspend_stb     (suspend_stb),
    .resume_stb      (resume_stb),
    .cfg_wr_stb      (cfg_wr_stb),
    .rd_sel          (rd_sel),
    .bypass_on       (bypass_on),
    .erase_suspended (erase_suspended)
);

// File: tb/test_flash_cmd_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module test_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 32;
    localparam logic [7:0] OPT = 8'h01;
    localparam int WATCHDOG_CYCLES = 20000;

    // strobe vector order: {prog, chip, sect, suspend, resume, cfg}
    localparam logic [5:0] ST_NONE = 6'b000000;
    localparam logic [5:0] ST_PROG = 6'b100000;
    localparam logic [5:0] ST_CHIP = 6'b010000;
    localparam logic [5:0] ST_SECT = 6'b001000;
    localparam logic [5:0] ST_SUSP = 6'b000100;
    localparam logic [5:0] ST_RES  = 6'b000010;
    localparam logic [5:0] ST_CFG  = 6'b000001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              acc_hv = 1'b0;
    logic              op_busy = 1'b0;
    logic [7:0]        rd_ofs = '0;
    logic              prog_stb, chip_erase_stb, sect_erase_stb;
    logic              suspend_stb, resume_stb, cfg_wr_stb;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [1:0]        rd_sel;
    logic [7:0]        id_byte;
    logic              bypass_on, erase_suspended;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .ID_OFS_W (8), .ORDER_OPT (OPT)
    ) i_flash_cmd_decoder (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .acc_hv (acc_hv), .op_busy (op_busy), .rd_ofs (rd_ofs),
        .prog_stb (prog_stb), .chip_erase_stb (chip_erase_stb),
        .sect_erase_stb (sect_erase_stb), .suspend_stb (suspend_stb),
        .resume_stb (resume_stb), .cfg_wr_stb (cfg_wr_stb), .op_addr (op_addr),
        .op_data (op_data), .rd_sel (rd_sel), .id_byte (id_byte),
        .bypass_on (bypass_on), .erase_suspended (erase_suspended)
    );

    function automatic logic [5:0] strobes();
        return {prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb, cfg_wr_stb};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write cycle; on return the registered result of that write is visible.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h00555, 32'h0000_00AA);
        wr(20'h002AA, 32'h0000_0055);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rd_sel", 64'(rd_sel), 64'd0);
        check("R1 strobes", 64'(strobes()), 64'(ST_NONE));
        check("R1 bypass", 64'(bypass_on), 64'd0);
        check("R1 suspended", 64'(erase_suspended), 64'd0);
    endtask

    task automatic t_program();
        // R5: high address and data bits set on every command write
        wr(20'hFF555, 32'hFFFF_FFAA);
        wr(20'hAB2AA, 32'h1234_5655);
        wr(20'h7F555, 32'hABCD_EFA0);
        check("R5 no early strobe", 64'(strobes()), 64'(ST_NONE));
        wr(20'h12345, 32'hDEAD_BEF0);
        check("R2 prog strobe", 64'(strobes()), 64'(ST_PROG));
        check("R2 prog addr", 64'(op_addr), 64'h12345);
        check("R2 prog data", 64'(op_data), 64'hDEAD_BEF0);
        idle(1);
        check("R2 strobe one cycle", 64'(strobes()), 64'(ST_NONE));
    endtask

    task automatic t_broken();
        wr(20'h00555, 32'hAA);
        wr(20'h002AB, 32'h55);
        wr(20'h00555, 32'hA0);
        wr(20'h00777, 32'h11);
        check("R4 broken unlock", 64'(strobes()), 64'(ST_NONE));
        unlock();
        wr(20'h00555, 32'h77);
        wr(20'h00123, 32'h22);
        check("R4 bad code", 64'(strobes()), 64'(ST_NONE));
        unlock();
        wr(20'h00555, 32'hA0);
        wr(20'h00456, 32'h33);
        check("R4 recovery prog", 64'(strobes()), 64'(ST_PROG));
        check("R4 recovery addr", 64'(op_addr), 64'h456);
    endtask

    task automatic t_autoselect();
        unlock();
        wr(20'h00555, 32'h90);
        check("R6 id select", 64'(rd_sel), 64'd1);
        rd_ofs = 8'h00; #1 check("R6 mfr id", 64'(id_byte), 64'h01);
        rd_ofs = 8'h01; #1 check("R6 dev 01", 64'(id_byte), 64'h7E);
        rd_ofs = 8'h0E; #1 check("R6 dev 0E", 64'(id_byte), 64'h09);
        rd_ofs = 8'h0F; #1 check("R6 dev 0F", 64'(id_byte), 64'(OPT));
        rd_ofs = 8'h05; #1 check("R6 other", 64'(id_byte), 64'h00);
        unlock();
        wr(20'h00555, 32'hA0);
        wr(20'h00100, 32'h44);
        check("R6 writes ignored", 64'(strobes()), 64'(ST_NONE));
        check("R6 still id", 64'(rd_sel), 64'd1);
        wr(20'h00000, 32'hF0);
        check("R6 F0 exit", 64'(rd_sel), 64'd0);
    endtask

    task automatic t_query();
        wr(20'h00555, 32'h98);
        check("R7 wrong offset", 64'(rd_sel), 64'd0);
        wr(20'h10055, 32'h98);
        check("R7 query select", 64'(rd_sel), 64'd2);
        wr(20'h00000, 32'hF0);
        check("R7 F0 exit", 64'(rd_sel), 64'd0);
    endtask

    task automatic t_config();
        unlock();
        wr(20'h00555, 32'hD0);
        wr(20'h00000, 32'h0000_ABCD);
        check("R10 cfg strobe", 64'(strobes()), 64'(ST_CFG));
        check("R10 cfg data", 64'(op_data), 64'hABCD);
        op_busy = 1'b1;
        unlock();
        wr(20'h00555, 32'hD0);
        wr(20'h00000, 32'h0000_1111);
        check("R10 busy ignored", 64'(strobes()), 64'(ST_NONE));
        check("R10 data kept", 64'(op_data), 64'hABCD);
        op_busy = 1'b0;
        idle(2);
    endtask

    task automatic t_accel();
        acc_hv = 1'b0;
        wr(20'h00000, 32'hA0);
        wr(20'h00200, 32'h12);
        check("R11 no hv", 64'(strobes()), 64'(ST_NONE));
        acc_hv = 1'b1;
        wr(20'h00000, 32'hA0);
        wr(20'h00200, 32'h5A5A);
        check("R11 hv prog", 64'(strobes()), 64'(ST_PROG));
        check("R11 hv data", 64'(op_data), 64'h5A5A);
        acc_hv = 1'b0;
    endtask

    task automatic t_bypass();
        unlock();
        wr(20'h00555, 32'h20);
        check("R12 enter", 64'(bypass_on), 64'd1);
        wr(20'h00000, 32'hA0);
        wr(20'h00321, 32'h77);
        check("R12 prog", 64'(strobes()), 64'(ST_PROG));
        check("R12 prog addr", 64'(op_addr), 64'h321);
        wr(20'h00000, 32'h80);
        wr(20'h00000, 32'h10);
        check("R12 chip erase", 64'(strobes()), 64'(ST_CHIP));
        wr(20'h00000, 32'hF0);
        check("R12 F0 ignored", 64'(bypass_on), 64'd1);
        wr(20'h00000, 32'h90);
        wr(20'h00000, 32'h00);
        check("R12 exit", 64'(bypass_on), 64'd0);
    endtask

    task automatic erase_setup();
        unlock();
        wr(20'h00555, 32'h80);
        unlock();
    endtask

    task automatic t_erase_suspend();
        erase_setup();
        wr(20'h00555, 32'h10);
        check("R3 chip erase", 64'(strobes()), 64'(ST_CHIP));
        erase_setup();
        wr(20'h30000, 32'h30);
        check("R3 sector erase", 64'(strobes()), 64'(ST_SECT));
        check("R3 sector addr", 64'(op_addr), 64'h30000);
        op_busy = 1'b1;
        wr(20'h30000, 32'hB0);
        check("R8 suspend", 64'(strobes()), 64'(ST_SUSP));
        check("R8 suspended flag", 64'(erase_suspended), 64'd1);
        op_busy = 1'b0;
        idle(2);
        wr(20'h30000, 32'hB0);
        check("R8 second B0", 64'(strobes()), 64'(ST_NONE));
        wr(20'h00000, 32'hF0);
        check("R9 F0 keeps suspend", 64'(erase_suspended), 64'd1);
        erase_setup();
        wr(20'h00555, 32'h10);
        check("R13 erase refused", 64'(strobes()), 64'(ST_NONE));
        unlock();
        wr(20'h00555, 32'hD0);
        wr(20'h00000, 32'h2222);
        check("R10 cfg in suspend", 64'(strobes()), 64'(ST_NONE));
        unlock();
        wr(20'h00555, 32'hA0);
        wr(20'h40010, 32'h99);
        check("R13 prog in suspend", 64'(strobes()), 64'(ST_PROG));
        wr(20'h30000, 32'h30);
        check("R9 resume", 64'(strobes()), 64'(ST_RES));
        check("R9 suspend cleared", 64'(erase_suspended), 64'd0);
        op_busy = 1'b1;
        idle(2);
        op_busy = 1'b0;
        idle(2);
        wr(20'h30000, 32'hB0);
        check("R8 B0 after erase end", 64'(strobes()), 64'(ST_NONE));
        wr(20'h30000, 32'h30);
        check("R9 30 not suspended", 64'(strobes()), 64'(ST_NONE));
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_program();
        t_broken();
        t_autoselect();
        t_query();
        t_config();
        t_accel();
        t_bypass();
        t_erase_suspend();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

endmodule